// File: doc/BRIEF.md
# Core Clock Doze Controller

This block lowers the rate at which a processor core is clocked while the peripherals keep running at the full system clock rate. It makes two clock-enable outputs, one for the core and one for the peripherals. The peripheral enable is high on every system cycle. The core enable is also high on every cycle unless doze is switched on. While doze is on, the core enable pulses once every 2^k system cycles, where k is a 3-bit rate code held in a control register.

Software reaches one 16-bit control register through a write strobe and a read bus that is always valid. The register has three fields: a doze switch, the rate code, and a wake-on-interrupt flag. When the wake flag is set and an interrupt event arrives while the core is dozing, hardware clears the doze switch, and the core returns to full speed on the next cycle.

Inside, a sequencer has three states. RUN is full speed, with the core enabled every cycle. HOLD is dozing while the count runs, with the core gated off. FIRE is dozing in the one cycle where the core is enabled. The sequencer has four named transitions:
- ENTER: RUN to HOLD or FIRE, when the doze switch is set.
- LEAVE: any doze state to RUN, when software clears the switch.
- WAKE: any doze state to RUN, when hardware clears the switch.
- RETUNE: the rate code changes while dozing, and the count restarts at zero.

Inside doze, the sequencer goes HOLD to FIRE when the count reaches its limit (TICK). It goes FIRE to HOLD when the count wraps (REARM). With code 0 it stays in FIRE.

Top module: `doze_ctl_top`

## Requirements
- R1: `periph_en` is 1 on every cycle after reset, whatever the register holds and whatever the interrupt input does.
- R2: While the doze switch (bit 11) reads 0, `core_en` is 1 on every cycle.
- R3: The register layout is: bit 15 is the wake flag, bits 14:12 are the rate code k, and bit 11 is the doze switch. A write loads all three fields. Bits 10:0 always read as zero.
- R4: While the doze switch reads 1 with rate code k, `core_en` is 1 on exactly one cycle in every 2^k cycles. Code 0 gives 1 on every cycle, and code 7 gives one pulse in 128.
- R5: When the doze switch or the rate code changes, the count restarts. The first `core_en` pulse under the new setting falls in the 2^k-th cycle after the clock edge that changed the register.
- R6: After reset the register reads 0x0000 and `core_en` is 1.
- R7: Suppose the wake flag is 1, the doze switch is 1, and `irq_evt` is high at a clock edge. After that edge the doze switch reads 0 and `core_en` is 1 on every cycle.
- R8: While the wake flag is 0, `irq_evt` changes neither the register nor the `core_en` pattern.
- R9: A register write can arrive in the same cycle as a hardware clear. In that case the written wake flag and rate code are loaded, but the doze switch reads 0 afterwards.
- R10: While the doze switch is 0, `irq_evt` does not change the register, even with the wake flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current contents of the control register |
| irq_evt | input | 1 | Interrupt event, one cycle per event |
| core_en | output | 1 | Clock enable for the core |
| periph_en | output | 1 | Clock enable for the peripherals |

## Verification
Two functions can land on the same clock edge: a software write to the register and the hardware clear caused by an interrupt. The bench creates this by holding `wr_en` and `irq_evt` together while the wake flag and doze switch are both set. It then checks that the written rate code and wake flag were loaded and that the doze switch reads zero. A second overlap comes from rewriting the rate code in the middle of a doze period. The bench judges this by the spacing of the next `core_en` pulse, cycle by cycle, against a behavioural model that is also exercised with random writes and interrupts.

// File: rtl/doze_pkg.sv
package doze_pkg;
    parameter int REG_W   = 16;
    parameter int RATIO_W = 3;
    localparam int CNT_W     = (1 << RATIO_W) - 1;
    localparam int WAKE_BIT  = 15;
    localparam int RATE_LSB  = 12;
    localparam int RATE_MSB  = RATE_LSB + RATIO_W - 1;
    localparam int DOZE_BIT  = 11;

    typedef struct packed {
        logic               wake;
        logic [RATIO_W-1:0] rate;
        logic               doze;
    } cfg_t;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HOLD = 2'd1,
        ST_FIRE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/doze_cfg_reg.sv
module doze_cfg_reg
    import doze_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             irq_evt,
    output cfg_t             cfg_q,
    output cfg_t             cfg_d,
    output logic             cfg_chg
);
    logic hw_clear;
    logic unused_low;

    assign unused_low = ^wr_data[DOZE_BIT-1:0];
    assign hw_clear   = cfg_q.wake && cfg_q.doze && irq_evt;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.wake = wr_data[WAKE_BIT];
            cfg_d.rate = wr_data[RATE_MSB:RATE_LSB];
            cfg_d.doze = wr_data[DOZE_BIT];
        end
        if (hw_clear) begin
            cfg_d.doze = 1'b0;
        end
    end

    assign cfg_chg = (cfg_d.doze != cfg_q.doze) || (cfg_d.rate != cfg_q.rate);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // R7
    wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.wake && cfg_q.doze && irq_evt) |=> !cfg_q.doze);

    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.wake && !wr_en && irq_evt) |=> $stable(cfg_q));

    // R9
    write_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && irq_evt && cfg_q.wake && cfg_q.doze)
        |=> (!cfg_q.doze && cfg_q.rate == $past(wr_data[RATE_MSB:RATE_LSB])));
endmodule

// File: rtl/doze_seq.sv
module doze_seq
    import doze_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cfg_t cfg_q,
    input  cfg_t cfg_d,
    input  logic cfg_chg,
    output logic core_en
);
    seq_state_t         st_q, st_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [CNT_W-1:0]   lim_q, lim_d;

    always_comb begin
        lim_q = CNT_W'((1 << cfg_q.rate) - 1);
        lim_d = CNT_W'((1 << cfg_d.rate) - 1);
    end

    // next state and counter
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!cfg_d.doze) begin
            st_d  = ST_RUN;                       // LEAVE / WAKE
            cnt_d = '0;
        end else if (cfg_chg) begin
            cnt_d = '0;                           // ENTER / RETUNE
            st_d  = (lim_d == '0) ? ST_FIRE : ST_HOLD;
        end else begin
            unique case (st_q)
                ST_HOLD: begin
                    cnt_d = cnt_q + 1'b1;
                    st_d  = (cnt_d == lim_q) ? ST_FIRE : ST_HOLD;  // TICK
                end
                ST_FIRE: begin
                    cnt_d = '0;
                    st_d  = (lim_q == '0) ? ST_FIRE : ST_HOLD;     // REARM
                end
                ST_RUN: begin
                    cnt_d = '0;
                    st_d  = (lim_q == '0) ? ST_FIRE : ST_HOLD;
                end
                default: begin
                    cnt_d = '0;
                    st_d  = ST_RUN;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            ST_HOLD: core_en = 1'b0;
            ST_FIRE: core_en = 1'b1;
            ST_RUN:  core_en = 1'b1;
            default: core_en = 1'b1;
        endcase
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim_q);

    // R4
    fire_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FIRE && lim_q != '0 && !cfg_chg && cfg_d.doze) |=> !core_en);

    // R2
    run_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.doze |-> core_en);
endmodule

// File: rtl/doze_ctl_top.sv
module doze_ctl_top
    import doze_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             irq_evt,
    output logic             core_en,
    output logic             periph_en
);
    cfg_t cfg_q, cfg_d;
    logic cfg_chg;

    doze_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .irq_evt (irq_evt),
        .cfg_q   (cfg_q),
        .cfg_d   (cfg_d),
        .cfg_chg (cfg_chg)
    );

    doze_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_q   (cfg_q),
        .cfg_d   (cfg_d),
        .cfg_chg (cfg_chg),
        .core_en (core_en)
    );

    always_comb begin
        rd_data = '0;
        rd_data[WAKE_BIT]          = cfg_q.wake;
        rd_data[RATE_MSB:RATE_LSB] = cfg_q.rate;
        rd_data[DOZE_BIT]          = cfg_q.doze;
    end

    assign periph_en = 1'b1;

    // R6
    reset_val_chk: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0 && core_en));

    // R10
    idle_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.doze && !wr_en && irq_evt) |=> $stable(rd_data));
endmodule

// File: tb/doze_ctl_top_tb_top.sv
`timescale 1ns/1ps
module doze_ctl_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        irq_evt = 1'b0;
    logic [15:0] rd_data;
    logic        core_en, periph_en;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit cmp_on = 0;

    int m_doze, m_rate, m_wake, m_cnt;

    always #4 clk = ~clk;

    doze_ctl_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq_evt(irq_evt), .core_en(core_en),
        .periph_en(periph_en)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference, updated at every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_doze = 0; m_rate = 0; m_wake = 0; m_cnt = 0;
        end else begin
            int nd, nr, nw;
            nd = m_doze; nr = m_rate; nw = m_wake;
            if (wr_en) begin
                nw = wr_data[15]; nr = wr_data[14:12]; nd = wr_data[11];
            end
            if (m_wake == 1 && m_doze == 1 && irq_evt) nd = 0;
            if (nd != m_doze || nr != m_rate) m_cnt = 0;
            else if (m_doze == 1) m_cnt = (m_cnt == (1 << m_rate) - 1) ? 0 : m_cnt + 1;
            else m_cnt = 0;
            m_doze = nd; m_rate = nr; m_wake = nw;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && cmp_on && !done) begin
            logic exp_core;
            exp_core = (m_doze == 0) || (m_cnt == (1 << m_rate) - 1);
            check("R4 model core_en", {15'd0, core_en}, {15'd0, exp_core});
            check("R3 model rd_data", rd_data,
                  16'((m_wake << 15) | (m_rate << 12) | (m_doze << 11)));
            check("R1 periph_en", {15'd0, periph_en}, 16'd1);
        end
    end

    task automatic write_reg(logic wk, logic [2:0] rt, logic dz);
        wr_en = 1'b1;
        wr_data = {wk, rt, dz, 11'h5A5};
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6
        check("R6 reset rd_data", rd_data, 16'h0000);
        check("R6 reset core_en", {15'd0, core_en}, 16'd1);
        cmp_on = 1;

        // R2: doze off, core every cycle
        for (int i = 0; i < 6; i++) begin
            check("R2 core_en off", {15'd0, core_en}, 16'd1);
            @(negedge clk);
        end

        // R3: layout and reserved bits
        write_reg(1'b1, 3'd6, 1'b0);
        check("R3 layout", rd_data, 16'hE000);

        // R10: irq with wake set but doze off
        irq_evt = 1'b1; @(negedge clk); irq_evt = 1'b0;
        check("R10 irq while awake", rd_data, 16'hE000);

        // R4 / R5: every rate code, spacing from the change edge
        for (int k = 0; k < 8; k++) begin
            int n;
            n = 1 << k;
            write_reg(1'b0, 3'(k), 1'b1);
            for (int i = 1; i <= 3 * n; i++) begin
                if (i == n) check("R5 first pulse", {15'd0, core_en}, 16'd1);
                else check("R4 spacing", {15'd0, core_en}, {15'd0, (i % n) == 0});
                if (i < 3 * n) @(negedge clk);
            end
        end

        // R5: retune mid-period
        write_reg(1'b0, 3'd3, 1'b1);
        repeat (3) @(negedge clk);
        write_reg(1'b0, 3'd2, 1'b1);
        for (int i = 1; i <= 4; i++) begin
            check("R5 retune", {15'd0, core_en}, {15'd0, i == 4});
            @(negedge clk);
        end

        // R8: irq without wake flag
        write_reg(1'b0, 3'd2, 1'b1);
        repeat (2) @(negedge clk);
        irq_evt = 1'b1; @(negedge clk); irq_evt = 1'b0;
        check("R8 irq masked", rd_data, 16'h2800);

        // R7: wake on interrupt
        write_reg(1'b1, 3'd3, 1'b1);
        repeat (5) @(negedge clk);
        irq_evt = 1'b1; @(negedge clk); irq_evt = 1'b0;
        check("R7 doze cleared", rd_data, 16'hB000);
        for (int i = 0; i < 4; i++) begin
            check("R7 full speed", {15'd0, core_en}, 16'd1);
            @(negedge clk);
        end

        // R9: write and hardware clear on the same edge
        write_reg(1'b1, 3'd1, 1'b1);
        @(negedge clk);
        irq_evt = 1'b1;
        write_reg(1'b1, 3'd5, 1'b1);
        irq_evt = 1'b0;
        check("R9 collision", rd_data, 16'hD000);

        // mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            wr_en = ($urandom % 23) == 0;
            wr_data = 16'($urandom);
            irq_evt = ($urandom % 11) == 0;
            @(negedge clk);
        end
        wr_en = 1'b0; irq_evt = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule